// File: doc/BRIEF.md
# Protected Real-Time Clock Counter

This block keeps wall-clock time as a chain of four counters: hundredths of a second, seconds, minutes and hours. A slow reference tick (nominally 32,768 per second) arrives as a one-cycle enable on the system clock. A fractional accumulator turns it into a hundredths step. Each counter wraps and carries one step into the next. The hour counter wraps either after 23 or after 255, as a configuration bit selects. The hour rollover is the "midnight" event. It sets a sticky flag, holds a pending-interrupt output high and emits a one-cycle wake pulse.

The host writes through a simple address/data strobe. Time writes pass only while an 8-bit key register holds the unlock value. Software must clear the key itself, because the block never relocks on its own. Configuration writes go through a staged path clocked by a second, slower tick (nominally 128 per second), so a new mode takes effect some time after the write. The counters never pause. A host that reads several of them must read the hundredths value again to detect a carry that occurred between reads.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, n reference ticks advance the time by exactly floor(n*100/32768) hundredths, counted across the hundredths and seconds fields.
- R2: Hundredths wraps 99→0 and seconds and minutes wrap 59→0; each wrap adds one to the next field in the same cycle.
- R3: A write to address 0 (hundredths), 1 (seconds), 2 (minutes) or 3 (hours) loads wr_data only while the key register (address 4) holds 0xEA; otherwise the counter is unchanged.
- R4: The key register keeps its value until the host overwrites it, so several time writes may follow one unlock; writing any other value relocks.
- R5: With configuration bit 0 (address 5) at 0 the hour counter wraps 23→0; with it at 1 it wraps 255→0 and passes through 24.
- R6: An hour wrap sets the midnight flag and irq_pending_o; both stay high until the host writes address 6 with bit 0 set; a write to address 6 with bit 0 clear has no effect.
- R7: Each hour wrap produces exactly one wake_o pulse of one clock cycle.
- R8: A configuration write becomes visible on mode_256h_o at the second slow_tick after the write, and not at the first.
- R9: After reset all counters, the key, the mode, the flag, the interrupt and the wake output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| slow_tick | input | 1 | One-cycle enable at the 128 Hz configuration rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| hsec_o | output | 8 | Hundredths counter |
| sec_o | output | 8 | Seconds counter |
| min_o | output | 8 | Minutes counter |
| hour_o | output | 8 | Hours counter |
| mode_256h_o | output | 1 | Active hour mode (1 = 256-hour wrap) |
| midnight_o | output | 1 | Sticky midnight flag |
| irq_pending_o | output | 1 | Pending interrupt from the midnight flag |
| wake_o | output | 1 | One-cycle wake pulse on hour wrap |

## Verification
The embedded properties check several rules on every cycle. A locked time write never disturbs the hour. The key holds unless rewritten. A wrapping field lands on zero. The midnight flag stays set without a clear, and the wake pulse never lasts two cycles. The active mode moves only on a slow tick, and hundredths steps never come back to back. Only the bench scenarios show the rest. The exact tick-to-time arithmetic comes from a long sweep. The rollover points in both hour modes, the exact two-tick configuration latency, and the clear-bit behaviour come from directed sequences that compare the ports against values computed from the tick count.

// File: rtl/rtc_tk_pkg.sv
`timescale 1ns/1ps
package rtc_tk_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 3;
   localparam int NUM_FIELDS = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_HSEC = 3'd0,
      REG_SEC  = 3'd1,
      REG_MIN  = 3'd2,
      REG_HOUR = 3'd3,
      REG_KEY  = 3'd4,
      REG_CFG  = 3'd5,
      REG_FLAG = 3'd6,
      REG_NONE = 3'd7
   } rtc_reg_e;

   localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hEA;
endpackage

// File: rtl/rtc_frac_tick.sv
`timescale 1ns/1ps
module rtc_frac_tick #(
   parameter int REF_HZ = 32768,
   parameter int RATE   = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick_i,
   output logic step_o
);
   localparam int ACC_W = $clog2(REF_HZ + RATE);
   localparam logic [ACC_W-1:0] REF_V  = ACC_W'(REF_HZ);
   localparam logic [ACC_W-1:0] RATE_V = ACC_W'(RATE);

   if (2 * RATE > REF_HZ) begin : g_bad_rate
      $error("rtc_frac_tick: RATE must not exceed half of REF_HZ");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;

   assign sum    = acc_q + RATE_V;
   assign step_o = ref_tick_i && (sum >= REF_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ref_tick_i) begin
         acc_q <= step_o ? (sum - REF_V) : sum;
      end
   end

   assert_step_sparse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);
endmodule

// File: rtl/rtc_wrap_cnt.sv
`timescale 1ns/1ps
module rtc_wrap_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic [W-1:0] last_i,
   output logic [W-1:0] value_o,
   output logic         carry_o
);
   if (W < 1) begin : g_bad_w
      $error("rtc_wrap_cnt: W must be positive");
   end

   logic [W-1:0] value_q;

   assign value_o = value_q;
   assign carry_o = step_i && !load_i && (value_q >= last_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= '0;
      end else if (load_i) begin
         value_q <= load_val_i;
      end else if (step_i) begin
         value_q <= carry_o ? '0 : value_q + 1'b1;
      end
   end

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> (value_o == '0));
endmodule

// File: rtl/rtc_cfg_sync.sv
`timescale 1ns/1ps
module rtc_cfg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wr_val_i,
   input  logic         slow_tick_i,
   output logic [W-1:0] active_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("rtc_cfg_sync: STAGES must be at least one");
   end

   logic [W-1:0] shadow_q;
   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_i) begin
         shadow_q <= wr_val_i;
      end
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q[k] <= '0;
         end else if (slow_tick_i) begin
            if (k == 0) begin
               pipe_q[k] <= shadow_q;
            end else begin
               pipe_q[k] <= pipe_q[(k == 0) ? 0 : k - 1];
            end
         end
      end
   end

   assign active_o = pipe_q[STAGES-1];

   assert_cfg_slow_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_tick_i |=> $stable(active_o));
endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper
   import rtc_tk_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int REF_HZ       = 32768,
   parameter int TICK_RATE    = 100,
   parameter int HSEC_COUNT   = 100,
   parameter int SEC_COUNT    = 60,
   parameter int MIN_COUNT    = 60,
   parameter int DAY_HOURS    = 24,
   parameter int LONG_HOURS   = 256,
   parameter int CFG_STAGES   = 2,
   parameter bit LONG_HOUR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              slow_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  hsec_o,
   output logic [CNT_W-1:0]  sec_o,
   output logic [CNT_W-1:0]  min_o,
   output logic [CNT_W-1:0]  hour_o,
   output logic              mode_256h_o,
   output logic              midnight_o,
   output logic              irq_pending_o,
   output logic              wake_o
);
   localparam int MAX_COUNT = 2 ** CNT_W;
   localparam logic [CNT_W-1:0] HSEC_LAST = CNT_W'(HSEC_COUNT - 1);
   localparam logic [CNT_W-1:0] SEC_LAST  = CNT_W'(SEC_COUNT - 1);
   localparam logic [CNT_W-1:0] MIN_LAST  = CNT_W'(MIN_COUNT - 1);
   localparam logic [CNT_W-1:0] DAY_LAST  = CNT_W'(DAY_HOURS - 1);
   localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_HOURS - 1);

   if (HSEC_COUNT > MAX_COUNT || SEC_COUNT > MAX_COUNT || MIN_COUNT > MAX_COUNT ||
       DAY_HOURS > MAX_COUNT || LONG_HOURS > MAX_COUNT) begin : g_bad_count
      $error("rtc_timekeeper: a wrap count does not fit CNT_W");
   end
   if (CNT_W < DATA_W) begin : g_bad_width
      $error("rtc_timekeeper: CNT_W must cover the host data width");
   end

   rtc_reg_e          addr_e;
   logic [DATA_W-1:0] key_q;
   logic              key_open;
   logic              wr_time;
   logic              hsec_step;
   logic              flag_q;
   logic              wake_q;
   logic              flag_clear;
   logic              mode_active;

   logic [CNT_W-1:0] cnt_v   [NUM_FIELDS];
   logic [CNT_W-1:0] last_v  [NUM_FIELDS];
   logic             step_v  [NUM_FIELDS];
   logic             carry_v [NUM_FIELDS];
   logic             load_v  [NUM_FIELDS];

   assign addr_e     = rtc_reg_e'(wr_addr);
   assign key_open   = (key_q == UNLOCK_KEY);
   assign wr_time    = wr_en && key_open;
   assign flag_clear = wr_en && (addr_e == REG_FLAG) && wr_data[0];

   // unlock key: held until the host rewrites it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (wr_en && addr_e == REG_KEY) begin
         key_q <= wr_data;
      end
   end

   rtc_frac_tick #(
      .REF_HZ (REF_HZ),
      .RATE   (TICK_RATE)
   ) frac_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick_i (ref_tick),
      .step_o     (hsec_step)
   );

   rtc_cfg_sync #(
      .W      (1),
      .STAGES (CFG_STAGES)
   ) cfg_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_en && addr_e == REG_CFG),
      .wr_val_i    (wr_data[0]),
      .slow_tick_i (slow_tick),
      .active_o    (mode_active)
   );

   assign last_v[0] = HSEC_LAST;
   assign last_v[1] = SEC_LAST;
   assign last_v[2] = MIN_LAST;

   if (LONG_HOUR_EN) begin : g_long_hour
      assign last_v[3] = mode_active ? LONG_LAST : DAY_LAST;
   end else begin : g_day_hour
      assign last_v[3] = DAY_LAST;
   end

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      if (i == 0) begin : g_first
         assign step_v[i] = hsec_step;
      end else begin : g_next
         assign step_v[i] = carry_v[(i == 0) ? 0 : i - 1];
      end
      assign load_v[i] = wr_time && (wr_addr == ADDR_W'(i));

      rtc_wrap_cnt #(
         .W (CNT_W)
      ) cnt_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .step_i     (step_v[i]),
         .load_i     (load_v[i]),
         .load_val_i (CNT_W'(wr_data)),
         .last_i     (last_v[i]),
         .value_o    (cnt_v[i]),
         .carry_o    (carry_v[i])
      );
   end

   // midnight flag: set wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         wake_q <= carry_v[3];
         if (carry_v[3]) begin
            flag_q <= 1'b1;
         end else if (flag_clear) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign hsec_o        = cnt_v[0];
   assign sec_o         = cnt_v[1];
   assign min_o         = cnt_v[2];
   assign hour_o        = cnt_v[3];
   assign mode_256h_o   = mode_active;
   assign midnight_o    = flag_q;
   assign irq_pending_o = flag_q;
   assign wake_o        = wake_q;

   assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_e == REG_HOUR && !key_open && !carry_v[2]) |=> $stable(hour_o));

   assert_key_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_open && !(wr_en && addr_e == REG_KEY)) |=> key_open);

   assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(midnight_o) |-> (hour_o == '0));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (midnight_o && !flag_clear) |=> midnight_o);

   assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);
endmodule

// File: tb/rtc_timekeeper_tb.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic       slow_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] hsec_o, sec_o, min_o, hour_o;
   logic       mode_256h_o, midnight_o, irq_pending_o, wake_o;

   int tests = 0;
   int fails = 0;
   int wake_cnt = 0;

   always #5 clk = ~clk;

   rtc_timekeeper dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_tick      (ref_en),
      .slow_tick     (slow_tick),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .hsec_o        (hsec_o),
      .sec_o         (sec_o),
      .min_o         (min_o),
      .hour_o        (hour_o),
      .mode_256h_o   (mode_256h_o),
      .midnight_o    (midnight_o),
      .irq_pending_o (irq_pending_o),
      .wake_o        (wake_o)
   );

   always @(negedge clk) if (rst_n && wake_o) wake_cnt++;

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ref_en = 1'b0;
      slow_tick = 1'b0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wake_cnt = 0;
      @(negedge clk);
   endtask

   task automatic host_write(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_ticks(input int k);
      ref_en = 1'b1;
      repeat (k) @(negedge clk);
      ref_en = 1'b0;
   endtask

   task automatic slow_pulse();
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_time(input int h, input int m, input int s, input int c);
      host_write(3'd4, 8'hEA);
      host_write(3'd3, 8'(h));
      host_write(3'd2, 8'(m));
      host_write(3'd1, 8'(s));
      host_write(3'd0, 8'(c));
      host_write(3'd4, 8'h00);
   endtask

   initial begin
      #2_000_000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      longint n;
      longint total;
      // R9 reset state
      do_reset();
      check("R9 hsec", hsec_o, 0);
      check("R9 sec", sec_o, 0);
      check("R9 min", min_o, 0);
      check("R9 hour", hour_o, 0);
      check("R9 mode", mode_256h_o, 0);
      check("R9 flag", midnight_o, 0);
      check("R9 irq", irq_pending_o, 0);
      check("R9 wake", wake_o, 0);

      // R1 sweep of tick counts from reset
      n = 0;
      for (int j = 0; j < 345; j++) begin
         run_ticks(97);
         n += 97;
         total = (n * 100) / 32768;
         check("R1 hsec", hsec_o, total % 100);
         check("R1 sec", sec_o, (total / 100) % 60);
      end

      // R1 first step boundary
      do_reset();
      run_ticks(327);
      check("R1 before step", hsec_o, 0);
      run_ticks(1);
      check("R1 at step", hsec_o, 1);

      // R3 / R4 key gating
      do_reset();
      host_write(3'd3, 8'd5);
      check("R3 locked hour", hour_o, 0);
      host_write(3'd4, 8'hEB);
      host_write(3'd3, 8'd5);
      check("R3 wrong key hour", hour_o, 0);
      host_write(3'd4, 8'hEA);
      host_write(3'd3, 8'd5);
      check("R3 unlocked hour", hour_o, 5);
      host_write(3'd2, 8'd7);
      check("R4 second write min", min_o, 7);
      host_write(3'd1, 8'd9);
      check("R4 third write sec", sec_o, 9);
      host_write(3'd4, 8'h00);
      host_write(3'd3, 8'd9);
      check("R4 relocked hour", hour_o, 5);
      host_write(3'd0, 8'd42);
      check("R4 relocked hsec", hsec_o, 0);

      // R2 carries
      do_reset();
      set_time(2, 3, 59, 99);
      run_ticks(327);
      check("R2 hold hsec", hsec_o, 99);
      run_ticks(1);
      check("R2 hsec wrap", hsec_o, 0);
      check("R2 sec wrap", sec_o, 0);
      check("R2 min carry", min_o, 4);
      check("R2 hour kept", hour_o, 2);
      do_reset();
      set_time(1, 59, 59, 99);
      run_ticks(328);
      check("R2 min wrap", min_o, 0);
      check("R2 hour carry", hour_o, 2);

      // R5 / R6 / R7 24-hour wrap
      do_reset();
      set_time(23, 59, 59, 99);
      run_ticks(327);
      check("R5 before wrap", hour_o, 23);
      check("R6 flag before", midnight_o, 0);
      run_ticks(1);
      check("R5 24h wrap", hour_o, 0);
      check("R6 flag set", midnight_o, 1);
      check("R6 irq set", irq_pending_o, 1);
      @(negedge clk);
      @(negedge clk);
      check("R7 one wake", wake_cnt, 1);
      check("R7 wake low", wake_o, 0);
      host_write(3'd6, 8'h00);
      check("R6 clear bit0 zero ignored", midnight_o, 1);
      host_write(3'd6, 8'h01);
      check("R6 flag cleared", midnight_o, 0);
      check("R6 irq cleared", irq_pending_o, 0);

      // R8 config latency
      do_reset();
      host_write(3'd5, 8'h01);
      check("R8 before ticks", mode_256h_o, 0);
      slow_pulse();
      check("R8 after first tick", mode_256h_o, 0);
      slow_pulse();
      check("R8 after second tick", mode_256h_o, 1);

      // R5 256-hour wrap
      set_time(23, 59, 59, 99);
      run_ticks(328);
      check("R5 256h passes 24", hour_o, 24);
      check("R6 no flag at 24", midnight_o, 0);
      check("R7 no wake at 24", wake_cnt, 0);
      set_time(255, 59, 59, 99);
      run_ticks(328);
      check("R5 256h wrap", hour_o, 0);
      check("R6 256h flag", midnight_o, 1);
      @(negedge clk);
      check("R7 256h wake", wake_cnt, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule